// File: doc/BRIEF.md
# Flag-setting add and compare unit

This unit is the add/compare slice of a 32-bit predicated integer datapath. Each cycle it takes one decoded operation with two register operands and an immediate field, and forms a 32-bit sum or difference with combinational logic. The unit holds a 4-bit registered status word with sign, carry, overflow and zero flags. The result and the register write strobe are valid in the same cycle. The status word changes at the next rising clock edge.

Add and add-immediate write the destination register. The per-instruction update bit decides whether they also write the flags, and the carry-in option adds the stored carry flag. Compare and compare-immediate only write the flags. In a subtraction the carry flag is a borrow, so carry set means the first operand is unsigned-below the second. A move-to-status operation loads the four flags straight from an operand. A failed predicate blocks every state change of the instruction.

Top module: `addcmp_unit`

## Requirements
- R1: While rst_ni is low, flags_o is 4'b0000 at once, without waiting for a clock edge.
- R2: For add (op_i = 3'd1) with carry_en_i = 0, result_o is src_a_i + src_b_i modulo 2^32 in the same cycle. When cond_pass_i = 1, rd_we_o is 1 in the same cycle.
- R3: For add and add-immediate, carry_en_i = 1 adds the stored carry flag (flags_o[2]) as carry-in. Setting carry_en_i = 0 adds nothing.
- R4: After an add or add-immediate with upd_en_i = 1, flags_o at the next edge is {SF, CF, OF, ZF}. Bit 3 (SF) is the result MSB. Bit 2 (CF) is the carry out of bit 31. Bit 1 (OF) is signed overflow. Bit 0 (ZF) is set when the result is zero.
- R5: An add or add-immediate with upd_en_i = 0 leaves flags_o unchanged, and the register write still takes place.
- R6: Compare (op_i = 3'd3) forms src_a_i - src_b_i on result_o and keeps rd_we_o at 0. It writes the flags whatever upd_en_i is, and it ignores carry_en_i. CF is 1 exactly when src_a_i < src_b_i as unsigned numbers. OF is the signed overflow of the subtraction.
- R7: Compare-immediate (op_i = 3'd4) acts like compare, but its second operand is imm_i[15:0] sign-extended to 32 bits.
- R8: Add-immediate (op_i = 3'd2) uses imm_i[11:0] as its second operand. The value is sign-extended when imm_sign_i = 1 and zero-extended when imm_sign_i = 0, and imm_i[15:12] is ignored.
- R9: With cond_pass_i = 0, rd_we_o is 0 and flags_o does not change at the next edge, whatever the operation.
- R10: Move-to-status (op_i = 3'd5) with cond_pass_i = 1 loads flags_o from src_a_i[3:0] at the next edge, and keeps rd_we_o at 0.
- R11: The op codes 3'd0, 3'd6 and 3'd7 do nothing: rd_we_o stays 0 and flags_o does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation: 0 none, 1 add, 2 add-immediate, 3 compare, 4 compare-immediate, 5 move-to-status, 6 and 7 none |
| cond_pass_i | input | 1 | Predicate outcome; 0 blocks all state changes |
| carry_en_i | input | 1 | Add the stored carry flag (add and add-immediate only) |
| upd_en_i | input | 1 | Write the flags on add and add-immediate |
| imm_sign_i | input | 1 | Sign-extend the 12-bit add immediate |
| src_a_i | input | 32 | First operand; for move-to-status, bits 3:0 are the new flags |
| src_b_i | input | 32 | Second register operand |
| imm_i | input | 16 | Immediate field |
| result_o | output | 32 | Sum or difference |
| rd_we_o | output | 1 | Destination register write strobe |
| flags_o | output | 4 | Status word {SF, CF, OF, ZF} |

## Verification
Adds are tried on small operands, on an unsigned wrap and on a wrap into the signed bit. Together these separate the carry flag from the overflow flag, and the carry-in is applied with the stored carry set and with it clear. Compares are tried on a lower, an equal and a signed-overflowing operand pair. This shows that CF acts as a borrow and that compare ignores both the update bit and the carry-in. Immediates with the top bit set, taken as signed and as unsigned, show the extension and the masking of the upper field bits. Flags loaded by move-to-status are then held through a failed predicate and through the no-op codes.

// File: rtl/addcmp_pkg.sv
package addcmp_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_ADD   = 3'd1,
    OP_ADDI  = 3'd2,
    OP_CMP   = 3'd3,
    OP_CMPI  = 3'd4,
    OP_MOVPS = 3'd5
  } op_e;

  // bit order is architectural: {SF, CF, OF, ZF}
  typedef struct packed {
    logic sf;
    logic cf;
    logic of;
    logic zf;
  } flags_t;
endpackage

// File: rtl/addcmp_opsel.sv
module addcmp_opsel
  import addcmp_pkg::*;
#(
  parameter int W      = 32,
  parameter int IMM_W  = 16,
  parameter int AIMM_W = 12
) (
  input  op_e              op_i,
  input  logic             imm_sign_i,
  input  logic [W-1:0]     src_b_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [W-1:0]     opnd_b_o,
  output logic             is_sub_o
);
  localparam int AEXT = W - AIMM_W;
  localparam int CEXT = W - IMM_W;

  logic [W-1:0] addi_b, cmpi_b;

  assign addi_b = {{AEXT{imm_i[AIMM_W-1] & imm_sign_i}}, imm_i[AIMM_W-1:0]};
  assign cmpi_b = {{CEXT{imm_i[IMM_W-1]}}, imm_i};

  always_comb begin
    opnd_b_o = src_b_i;
    is_sub_o = 1'b0;
    case (op_i)
      OP_ADDI: opnd_b_o = addi_b;
      OP_CMP:  is_sub_o = 1'b1;
      OP_CMPI: begin
        opnd_b_o = cmpi_b;
        is_sub_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/addcmp_core.sv
module addcmp_core
  import addcmp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         is_sub_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output flags_t       flags_o
);
  logic [W-1:0] b_eff;
  logic         c0;
  logic [W:0]   ext;

  assign b_eff = is_sub_i ? ~b_i : b_i;
  assign c0    = is_sub_i | cin_i;
  assign ext   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, c0};
  assign sum_o = ext[W-1:0];

  assign flags_o.sf = ext[W-1];
  // subtraction reports borrow: set when a < b unsigned
  assign flags_o.cf = is_sub_i ? ~ext[W] : ext[W];
  assign flags_o.of = (a_i[W-1] == b_eff[W-1]) && (ext[W-1] != a_i[W-1]);
  assign flags_o.zf = (ext[W-1:0] == '0);
endmodule

// File: rtl/addcmp_status.sv
module addcmp_status
  import addcmp_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   we_i,
  input  flags_t d_i,
  output flags_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/addcmp_unit.sv
module addcmp_unit
  import addcmp_pkg::*;
#(
  parameter int W      = 32,
  parameter int IMM_W  = 16,
  parameter int AIMM_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       op_i,
  input  logic             cond_pass_i,
  input  logic             carry_en_i,
  input  logic             upd_en_i,
  input  logic             imm_sign_i,
  input  logic [W-1:0]     src_a_i,
  input  logic [W-1:0]     src_b_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [W-1:0]     result_o,
  output logic             rd_we_o,
  output logic [3:0]       flags_o
);
  op_e          op;
  logic         is_add, is_cmp, is_mov;
  logic [W-1:0] opnd_b;
  logic         is_sub, cin, flag_we;
  flags_t       core_flags, flag_d, flag_q;

  assign op     = op_e'(op_i);
  assign is_add = (op == OP_ADD) || (op == OP_ADDI);
  assign is_cmp = (op == OP_CMP) || (op == OP_CMPI);
  assign is_mov = (op == OP_MOVPS);

  addcmp_opsel #(.W(W), .IMM_W(IMM_W), .AIMM_W(AIMM_W)) u_opsel (
    .op_i      (op),
    .imm_sign_i(imm_sign_i),
    .src_b_i   (src_b_i),
    .imm_i     (imm_i),
    .opnd_b_o  (opnd_b),
    .is_sub_o  (is_sub)
  );

  assign cin = is_add & carry_en_i & flag_q.cf;

  addcmp_core #(.W(W)) u_core (
    .a_i     (src_a_i),
    .b_i     (opnd_b),
    .is_sub_i(is_sub),
    .cin_i   (cin),
    .sum_o   (result_o),
    .flags_o (core_flags)
  );

  assign flag_d  = is_mov ? flags_t'(src_a_i[3:0]) : core_flags;
  assign flag_we = cond_pass_i & ((is_add & upd_en_i) | is_cmp | is_mov);
  assign rd_we_o = cond_pass_i & is_add;

  addcmp_status u_status (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (flag_we),
    .d_i   (flag_d),
    .q_o   (flag_q)
  );

  assign flags_o = flag_q;
endmodule

// File: rtl/addcmp_chk.sv
module addcmp_chk
  import addcmp_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       op_i,
  input logic             cond_pass_i,
  input logic             carry_en_i,
  input logic             upd_en_i,
  input logic             imm_sign_i,
  input logic [W-1:0]     src_a_i,
  input logic [W-1:0]     src_b_i,
  input logic [IMM_W-1:0] imm_i,
  input logic [W-1:0]     result_o,
  input logic             rd_we_o,
  input logic [3:0]       flags_o
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) reset_flags_chk: assert (flags_o == 4'b0000);
  end

  // R2
  add_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_ADD && !carry_en_i) |-> result_o == src_a_i + src_b_i);

  // R4
  add_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_ADD && cond_pass_i && upd_en_i && !carry_en_i)
      |=> flags_o[0] == ($past(src_a_i + src_b_i) == '0));

  // R5
  no_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op_i == OP_ADD || op_i == OP_ADDI) && !upd_en_i) |=> $stable(flags_o));

  // R6
  cmp_borrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CMP && cond_pass_i) |=> flags_o[2] == $past(src_a_i < src_b_i));

  // R6
  cmp_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CMP || op_i == OP_CMPI) |-> !rd_we_o);

  // R9
  pred_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cond_pass_i |=> $stable(flags_o));

  // R9
  pred_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cond_pass_i |-> !rd_we_o);

  // R10
  move_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_MOVPS && cond_pass_i) |=> flags_o == $past(src_a_i[3:0]));

  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd0 || op_i == 3'd6 || op_i == 3'd7) |=> $stable(flags_o));
endmodule

bind addcmp_unit addcmp_chk #(.W(W), .IMM_W(IMM_W)) u_chk (.*);

// File: tb/addcmp_unit_tb.sv
module addcmp_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = '0;
  logic        cpass = 1'b0, cen = 1'b0, upd = 1'b0, isgn = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic [15:0] imm = '0;
  logic [31:0] res;
  logic        we;
  logic [3:0]  fl;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  addcmp_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .cond_pass_i(cpass),
    .carry_en_i(cen), .upd_en_i(upd), .imm_sign_i(isgn),
    .src_a_i(a), .src_b_i(b), .imm_i(imm),
    .result_o(res), .rd_we_o(we), .flags_o(fl)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  op;
    logic        cp, ce, up, sg;
    logic [31:0] a, b;
    logic [15:0] imm;
    logic        chk_res;
    logic [31:0] res;
    logic        we;
    logic [3:0]  fl;
  } vec_t;

  localparam int NV = 22;
  // flags {SF,CF,OF,ZF}; each line continues from the previous flag state
  localparam vec_t VECS [NV] = '{
    '{4'd2,  3'd1, 1, 0, 1, 0, 32'h1,        32'h2,        16'h0,    1, 32'h3,        1, 4'b0000}, // R2
    '{4'd4,  3'd1, 1, 0, 1, 0, 32'hFFFFFFFF, 32'h1,        16'h0,    1, 32'h0,        1, 4'b0101}, // R4 carry+zero
    '{4'd3,  3'd1, 1, 1, 1, 0, 32'h5,        32'h6,        16'h0,    1, 32'hC,        1, 4'b0000}, // R3 cin=1
    '{4'd4,  3'd1, 1, 0, 1, 0, 32'h7FFFFFFF, 32'h1,        16'h0,    1, 32'h80000000, 1, 4'b1010}, // R4 overflow
    '{4'd5,  3'd1, 1, 0, 0, 0, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h0,    1, 32'hFFFFFFFE, 1, 4'b1010}, // R5
    '{4'd3,  3'd1, 1, 1, 1, 0, 32'hFFFFFFFF, 32'h0,        16'h0,    1, 32'hFFFFFFFF, 1, 4'b1000}, // R3 cf clear
    '{4'd6,  3'd3, 1, 1, 0, 0, 32'h3,        32'h5,        16'h0,    1, 32'hFFFFFFFE, 0, 4'b1100}, // R6 lower
    '{4'd6,  3'd3, 1, 0, 1, 0, 32'h5,        32'h5,        16'h0,    1, 32'h0,        0, 4'b0001}, // R6 equal
    '{4'd6,  3'd3, 1, 0, 1, 0, 32'h80000000, 32'h1,        16'h0,    1, 32'h7FFFFFFF, 0, 4'b0010}, // R6 overflow
    '{4'd7,  3'd4, 1, 0, 1, 0, 32'h0,        32'h0,        16'hFFFF, 1, 32'h1,        0, 4'b0100}, // R7
    '{4'd8,  3'd2, 1, 0, 1, 1, 32'hA,        32'h0,        16'h0FFF, 1, 32'h9,        1, 4'b0100}, // R8 signed
    '{4'd8,  3'd2, 1, 0, 1, 0, 32'hA,        32'h0,        16'hFFFF, 1, 32'h1009,     1, 4'b0000}, // R8 unsigned
    '{4'd10, 3'd5, 1, 0, 1, 0, 32'h0000000B, 32'h0,        16'h0,    0, 32'h0,        0, 4'b1011}, // R10
    '{4'd9,  3'd1, 0, 0, 1, 0, 32'hFFFFFFFF, 32'h1,        16'h0,    1, 32'h0,        0, 4'b1011}, // R9 add
    '{4'd9,  3'd3, 0, 0, 1, 0, 32'h0,        32'h1,        16'h0,    1, 32'hFFFFFFFF, 0, 4'b1011}, // R9 cmp
    '{4'd11, 3'd0, 1, 0, 1, 0, 32'h0,        32'h0,        16'h0,    0, 32'h0,        0, 4'b1011}, // R11 op0
    '{4'd11, 3'd7, 1, 0, 1, 0, 32'h0,        32'h0,        16'h0,    0, 32'h0,        0, 4'b1011}, // R11 op7
    '{4'd10, 3'd5, 1, 0, 1, 0, 32'hFFFFFFF4, 32'h0,        16'h0,    0, 32'h0,        0, 4'b0100}, // R10 upper ignored
    '{4'd3,  3'd1, 1, 1, 1, 0, 32'hFFFFFFFF, 32'h0,        16'h0,    1, 32'h0,        1, 4'b0101}, // R3 cin wraps
    '{4'd3,  3'd2, 1, 1, 1, 0, 32'h1,        32'h0,        16'h0002, 1, 32'h4,        1, 4'b0000}, // R3 addi cin
    '{4'd10, 3'd5, 1, 0, 1, 0, 32'h4,        32'h0,        16'h0,    0, 32'h0,        0, 4'b0100}, // R10
    '{4'd6,  3'd3, 1, 1, 1, 0, 32'h5,        32'h5,        16'h0,    1, 32'h0,        0, 4'b0001}  // R6 cin ignored
  };

  task automatic check(input logic ok, input string what, input int req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #5;
    // R1 during reset
    check(fl == 4'b0000, "flags in reset", 1, {28'h0, fl}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check(fl == 4'b0000, "flags after reset", 1, {28'h0, fl}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      op = VECS[i].op; cpass = VECS[i].cp; cen = VECS[i].ce;
      upd = VECS[i].up; isgn = VECS[i].sg;
      a = VECS[i].a; b = VECS[i].b; imm = VECS[i].imm;
      #1;
      if (VECS[i].chk_res)
        check(res == VECS[i].res, "result", int'(VECS[i].req), res, VECS[i].res);
      check(we == VECS[i].we, "write strobe", int'(VECS[i].req), {31'h0, we}, {31'h0, VECS[i].we});
      @(posedge clk);
      #1;
      check(fl == VECS[i].fl, "flags", int'(VECS[i].req), {28'h0, fl}, {28'h0, VECS[i].fl});
    end

    // R1: asynchronous reset mid-run clears nonzero flags before any edge
    @(negedge clk);
    op = 3'd0;
    #0.5;
    rst_n = 1'b0;
    #0.5;
    check(fl == 4'b0000, "async clear", 1, {28'h0, fl}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R9: move-to-status with failed predicate does nothing
    @(negedge clk);
    op = 3'd5; cpass = 1'b0; a = 32'hF;
    #1;
    check(we == 1'b0, "move no write", 9, {31'h0, we}, 32'h0);
    @(posedge clk);
    #1;
    check(fl == 4'b0000, "move blocked", 9, {28'h0, fl}, 32'h0);

    // R11: op 6 with flags nonzero
    @(negedge clk);
    op = 3'd5; cpass = 1'b1; a = 32'h6;
    @(negedge clk);
    op = 3'd6; a = 32'hFFFFFFFF; b = 32'h1;
    #1;
    check(we == 1'b0, "op6 no write", 11, {31'h0, we}, 32'h0);
    @(posedge clk);
    #1;
    check(fl == 4'b0110, "op6 holds", 11, {28'h0, fl}, 32'h6);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule